// File: doc/BRIEF.md
# Sorted Stream Merge with Duplicate Removal

This block joins two input token streams, each strictly increasing, into a single output stream. The output is in ascending order and holds no repeated value. Every input and the output use a valid/ready handshake. The token width is a parameter. Each input has one head register. The block acts only when both head registers are loaded. It then emits the smaller head and refills only the input that supplied it. When the heads are equal, it emits the value once and refills both inputs.

Reads are blocking. The block never looks past the current heads, and it never makes a choice based on whether an input is empty. An input whose head has not been consumed simply stops accepting tokens. Because of this, the output sequence depends only on the token values and not on when tokens arrive or when the output is stalled. A finite pair of streams therefore stops producing output as soon as one of them runs dry, because the block waits for a head that never comes. A head slot can be refilled in the same cycle that its old value is taken, so the block can sustain one output token per cycle.

Top module: `sorted_merge_dedup`

## Requirements
- R1: After synchronous reset, out_valid is 0 and both a_ready and b_ready are 1, because both head slots are empty.
- R2: No token is emitted while either head slot is empty. After an input has delivered a head that has not been consumed, that input's ready stays 0.
- R3: When the heads differ, the smaller one is emitted. Only the input that supplied it is refilled, and the other head is kept for the next comparison.
- R4: When the heads are equal, the value is emitted exactly once and both inputs are refilled.
- R5: The output sequence is the same whatever the input valid timing and output ready stalls.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data keeps its value in the next cycle.
- R7: With both inputs always valid and out_ready always 1, the block emits one token in every cycle of a run.
- R8: Heads are compared as unsigned numbers, so a value with the top bit set (for example 8'h80) orders above 8'h7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Stream A token offered |
| a_data | input | W | Stream A token value |
| a_ready | output | 1 | Stream A token accepted this cycle |
| b_valid | input | 1 | Stream B token offered |
| b_data | input | W | Stream B token value |
| b_ready | output | 1 | Stream B token accepted this cycle |
| out_valid | output | 1 | Merged token present |
| out_data | output | W | Merged token value |
| out_ready | input | 1 | Consumer takes the merged token |

## Verification
The ordering property holds only when each input stream is strictly increasing on its own. With that assumption, every accepted output token must be larger than the previous one. The stimulus supplies only strictly increasing value lists. It holds a valid token steady until that token is accepted, and it applies a reset before every new pair of lists, so the ordering history starts fresh each time. The stall patterns vary only handshake timing and never the values, so the same expected sequence applies to every timing pattern.

// File: rtl/smd_pkg.sv
package smd_pkg;

    typedef enum logic [1:0] {
        TAKE_A    = 2'b01,
        TAKE_B    = 2'b10,
        TAKE_BOTH = 2'b11
    } take_e;

    localparam int unsigned NUM_IN = 2;

    function automatic take_e decide(input logic a_lt_b, input logic a_eq_b);
        if (a_eq_b)      return TAKE_BOTH;
        else if (a_lt_b) return TAKE_A;
        else             return TAKE_B;
    endfunction

endpackage

// File: rtl/smd_head_slot.sv
module smd_head_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] head
);
    // refill allowed when empty or when the held head leaves this cycle
    assign in_ready = !full || take;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            head <= '0;
        end else if (in_valid && in_ready) begin
            full <= 1'b1;
            head <= in_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/smd_pick.sv
module smd_pick
    import smd_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] head_a,
    input  logic [W-1:0] head_b,
    output take_e        choice,
    output logic [W-1:0] low
);
    logic a_lt_b;
    logic a_eq_b;

    // operands are unsigned vectors, so the compare is unsigned
    assign a_lt_b = head_a < head_b;
    assign a_eq_b = head_a == head_b;
    assign choice = decide(a_lt_b, a_eq_b);
    assign low    = a_lt_b ? head_a : head_b;
endmodule

// File: rtl/smd_emit.sv
module smd_emit #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         room,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    assign room = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sorted_merge_dedup.sv
module sorted_merge_dedup
    import smd_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a_valid,
    input  logic [W-1:0] a_data,
    output logic         a_ready,
    input  logic         b_valid,
    input  logic [W-1:0] b_data,
    output logic         b_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    logic [NUM_IN-1:0] in_v;
    logic [NUM_IN-1:0] in_r;
    logic [NUM_IN-1:0] held;
    logic [NUM_IN-1:0] take;
    logic [W-1:0]      in_d  [NUM_IN];
    logic [W-1:0]      hd    [NUM_IN];
    take_e             choice;
    logic [W-1:0]      low;
    logic              room;
    logic              fire;

    assign in_v[0] = a_valid;
    assign in_v[1] = b_valid;
    assign in_d[0] = a_data;
    assign in_d[1] = b_data;
    assign a_ready = in_r[0];
    assign b_ready = in_r[1];

    generate
        for (genvar g = 0; g < NUM_IN; g++) begin : g_slot
            smd_head_slot #(.W(W)) u_slot (
                .clk      (clk),
                .rst      (rst),
                .in_valid (in_v[g]),
                .in_data  (in_d[g]),
                .in_ready (in_r[g]),
                .take     (take[g]),
                .full     (held[g]),
                .head     (hd[g])
            );
        end
    endgenerate

    smd_pick #(.W(W)) u_pick (
        .head_a (hd[0]),
        .head_b (hd[1]),
        .choice (choice),
        .low    (low)
    );

    // decide only when every head is present: blocking read
    assign fire = (&held) && room;
    assign take = fire ? NUM_IN'(choice) : '0;

    smd_emit #(.W(W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .load      (fire),
        .load_data (low),
        .room      (room),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );
endmodule

// File: rtl/smd_checker.sv
module smd_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         a_valid,
    input logic         a_ready,
    input logic         b_valid,
    input logic         b_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data
);
    logic         seen_a;
    logic         seen_b;
    logic         have_last;
    logic [W-1:0] last_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_a    <= 1'b0;
            seen_b    <= 1'b0;
            have_last <= 1'b0;
            last_val  <= '0;
        end else begin
            if (a_valid && a_ready) seen_a <= 1'b1;
            if (b_valid && b_ready) seen_b <= 1'b1;
            if (out_valid && out_ready) begin
                have_last <= 1'b1;
                last_val  <= out_data;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && a_ready && b_ready));

    p_wait_heads_r2: assert property (@(posedge clk) disable iff (rst)
        !(seen_a && seen_b) |-> !out_valid);

    // strict growth covers both ordering (R3) and single emission of ties (R4)
    p_ascending_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && have_last) |-> (out_data > last_val));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind sorted_merge_dedup smd_checker #(.W(W)) u_chk (.*);

// File: tb/sorted_merge_dedup_tb.sv
`timescale 1ns/1ps
module sorted_merge_dedup_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         a_valid = 1'b0, b_valid = 1'b0, out_ready = 1'b0;
    logic [W-1:0] a_data = '0, b_data = '0;
    logic         a_ready, b_ready, out_valid;
    logic [W-1:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [W-1:0] av[$];
    logic [W-1:0] bv[$];
    logic [W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    sorted_merge_dedup #(.W(W)) u_dut (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
        .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_pt();
        @(posedge clk); #1;
    endtask

    task automatic sample_pt();
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        drive_pt();
        rst = 1'b1; a_valid = 0; b_valid = 0; out_ready = 0;
        drive_pt(); drive_pt();
        rst = 1'b0;
    endtask

    // driver: builds the expected merged sequence, then runs the handshakes
    task automatic run_case(input string tag, input bit stall, input bit tput);
        int ia = 0, ib = 0, i = 0, j = 0, cyc = 0, idle = 0;
        int first_cyc = -1, last_cyc = -1, n_out = 0;
        bit prev_hold = 0;
        logic [W-1:0] prev_data = '0;
        exp_q.delete();
        while (i < av.size() && j < bv.size()) begin
            if (av[i] < bv[j])      begin exp_q.push_back(av[i]); i++; end
            else if (bv[j] < av[i]) begin exp_q.push_back(bv[j]); j++; end
            else begin exp_q.push_back(av[i]); i++; j++; end
        end
        do_reset();
        while (idle < 12 && cyc < 3000) begin
            if (!(a_valid && !a_ready_s)) begin
                a_valid = (ia < av.size()) && (!stall || ($urandom % 3 != 0));
                a_data  = (ia < av.size()) ? av[ia] : '0;
            end
            if (!(b_valid && !b_ready_s)) begin
                b_valid = (ib < bv.size()) && (!stall || ($urandom % 3 != 0));
                b_data  = (ib < bv.size()) ? bv[ib] : '0;
            end
            out_ready = !stall || ($urandom % 2 == 0);
            sample_pt();
            a_ready_s = a_ready;
            b_ready_s = b_ready;
            if (prev_hold) begin
                chk({"R6 hold valid ", tag}, out_valid, 1'b1);
                chk({"R6 hold data ", tag}, out_data, prev_data);
            end
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
            if (a_valid && a_ready) ia++;
            if (b_valid && b_ready) ib++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk({"unexpected token ", tag}, out_data, 32'hFFFF_FFFF);
                else chk(tag, out_data, exp_q.pop_front());
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                n_out++;
            end
            if (exp_q.size() == 0) idle++;
            cyc++;
            drive_pt();
        end
        chk({"remaining expected ", tag}, exp_q.size(), 0);
        if (tput) chk({"R7 one per cycle ", tag}, last_cyc - first_cyc + 1, n_out);
        a_valid = 0; b_valid = 0; a_ready_s = 1; b_ready_s = 1;
    endtask

    logic a_ready_s = 1'b1, b_ready_s = 1'b1;

    initial begin
        do_reset();
        sample_pt();
        chk("R1 out_valid after reset", out_valid, 1'b0);
        chk("R1 a_ready after reset", a_ready, 1'b1);
        chk("R1 b_ready after reset", b_ready, 1'b1);

        // R2: only stream A offers a token; nothing may be emitted
        drive_pt();
        a_valid = 1; a_data = 8'd5; out_ready = 1;
        sample_pt();
        drive_pt();
        a_valid = 1; a_data = 8'd7;
        for (int k = 0; k < 5; k++) begin
            sample_pt();
            chk("R2 a_ready low while A head held", a_ready, 1'b0);
            chk("R2 no output with one head", out_valid, 1'b0);
            drive_pt();
        end
        a_valid = 0; b_valid = 1; b_data = 8'd9;
        sample_pt();
        drive_pt();
        b_valid = 0;
        sample_pt();
        drive_pt();
        sample_pt();
        chk("R3 smaller head emitted", {out_valid, out_data}, {1'b1, 8'd5});
        chk("R3 B head kept, b_ready low", b_ready, 1'b0);
        drive_pt();

        // multiples of two and three
        av.delete(); bv.delete();
        for (int k = 1; k <= 20; k++) av.push_back(W'(2 * k));
        for (int k = 1; k <= 14; k++) bv.push_back(W'(3 * k));
        run_case("R3 R4 mult2/mult3", 0, 0);
        run_case("R5 mult2/mult3 stalled", 1, 0);

        // identical streams: every pair is a tie
        av.delete(); bv.delete();
        for (int k = 0; k < 10; k++) begin av.push_back(W'(4 * k + 1)); bv.push_back(W'(4 * k + 1)); end
        run_case("R4 identical streams", 0, 1);
        run_case("R5 identical streams stalled", 1, 0);

        // disjoint ranges at full rate
        av.delete(); bv.delete();
        for (int k = 0; k < 12; k++) av.push_back(W'(k + 1));
        for (int k = 0; k < 4; k++) bv.push_back(W'(100 + k));
        run_case("R7 disjoint full rate", 0, 1);

        // top-bit values must order as unsigned
        av.delete(); bv.delete();
        av = '{8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
        bv = '{8'h02, 8'h80, 8'h81, 8'hFF};
        run_case("R8 unsigned order", 0, 0);
        run_case("R8 unsigned order stalled", 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #900000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule